// File: doc/BRIEF.md
# Single-Channel DMA Sequencer

This block is one DMA channel. It keeps a source address, a destination address and a unit count. It copies data one unit at a time over a memory-style master port. Each unit is a read from the source followed by a write to the destination. Both phases use valid/ready handshakes. After each unit the count drops by one. When the count reaches zero the channel raises an end flag and stops until that flag is cleared.

A unit may start only when five conditions hold together:

- the channel enable is set;
- the global enable is set;
- the end flag is clear;
- the address-error input is low;
- the NMI input is low.

Requests come from one of three sources:

- **Automatic:** the channel runs by itself while enabled.
- **External pin:** active low and sampled as a level.
- **Peripheral line:** chosen by an 8-bit selector that combines a 6-bit module number with a 2-bit request kind.

In burst mode the channel keeps the bus from one unit to the next. In cycle-steal mode it gives the bus back after every unit.

Configuration arrives as plain inputs. A load strobe writes the addresses and the count, and a clear strobe resets the end flag. The live address and count registers are visible on outputs, so a system can observe progress.

Top module: `dma_channel`

## Requirements
- R1: A unit starts only when `ch_en`=1, `master_en`=1, `te`=0, `addr_err`=0 and `nmi_flag`=0. If any of these fails, the channel stays idle and the count does not change. After reset, `bus_own`, `rd_valid`, `wr_valid` and `te` are 0 and `cur_count` is 0.
- R2: With `req_mode`=00 (automatic), units start with no request input at all.
- R3: With `req_mode`=01, a low level on `ext_req_n` at a clock edge is a request. A request seen while a unit is in flight is latched and serves exactly one further unit.
- R4: With `req_mode`=10, `periph_sel`[7:2] picks module m. Kind `periph_sel`[1:0]=01 follows `periph_tx_req[m]`, kind 10 follows `periph_rx_req[m]`, and kinds 00 and 11 select nothing. Lines of other modules and the unselected kind have no effect.
- R5: Each unit reads `rd_addr`=`cur_src` and then writes the data it read to `wr_addr`=`cur_dst`. A phase holds its valid, address and data steady until ready is seen.
- R6: `unit_size` gives the unit width: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 is treated as 4 bytes. The value appears on `rd_size` and `wr_size`. After each unit, the source advances by the width when `src_inc`=1 and stays put when `src_inc`=0. The destination follows the same rule with `dst_inc`.
- R7: `cur_count` decrements by exactly one at each completed write and changes at no other time except a load.
- R8: When a write brings the count to zero, `te` becomes 1 on the next cycle. `end_irq` equals `te` AND `irq_en`. While `te`=1, all requests are ignored until `te_clr` is pulsed.
- R9: With `burst_mode`=1, `bus_own` stays high from the first unit until the count reaches zero, with no further request needed.
- R10: With `burst_mode`=0, `bus_own` goes low for at least one cycle after every unit.
- R11: If an enable condition of R1 fails during a unit, that unit completes, the count drops by exactly one, and then the channel idles. It resumes when the conditions hold again.
- R12: A count of zero never starts a unit. `cfg_load` takes effect only while `bus_own`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the addresses and the count |
| cfg_src | input | ADDR_W | Source address to load |
| cfg_dst | input | ADDR_W | Destination address to load |
| cfg_count | input | CNT_W | Unit count to load |
| ch_en | input | 1 | Channel enable |
| master_en | input | 1 | Global enable |
| te_clr | input | 1 | Clears the end flag |
| addr_err | input | 1 | Address error flag |
| nmi_flag | input | 1 | NMI flag |
| req_mode | input | 2 | 00 automatic, 01 external pin, 10 peripheral, 11 none |
| burst_mode | input | 1 | 1 burst, 0 cycle steal |
| unit_size | input | 2 | Unit width code |
| src_inc | input | 1 | Source address advances after each unit |
| dst_inc | input | 1 | Destination address advances after each unit |
| irq_en | input | 1 | End interrupt enable |
| periph_sel | input | MID_W+2 | Module number and request kind |
| ext_req_n | input | 1 | External request, active low |
| periph_tx_req | input | 2**MID_W | Transmit request line of each module |
| periph_rx_req | input | 2**MID_W | Receive request line of each module |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, data present |
| rd_addr | output | ADDR_W | Read address |
| rd_size | output | 2 | Read width code |
| rd_data | input | DATA_W | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | DATA_W | Write data |
| bus_own | output | 1 | Channel holds the bus |
| te | output | 1 | End flag |
| end_irq | output | 1 | End interrupt |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |
| cur_count | output | CNT_W | Remaining units |

## Verification
The hardest case to reach is a request or a disable that lands while a unit is held mid-flight. With random ready timing, this happens only by chance. The stimulus therefore forces both ready inputs low with a stall control. It waits until the channel has claimed the bus, and then acts on the stalled unit:

- pulses the external pin, or
- drops the global enable, or
- pulses a load.

It then releases the stall and counts completed units. A latched request must yield exactly one extra unit. A disable must let the current unit finish and then halt. The load must leave the count untouched.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int MID_W  = 6,
  localparam int NMOD  = 1 << MID_W,
  localparam int SEL_W = MID_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              ch_en,
  input  logic              master_en,
  input  logic              te_clr,
  input  logic              addr_err,
  input  logic              nmi_flag,
  input  logic [1:0]        req_mode,
  input  logic              burst_mode,
  input  logic [1:0]        unit_size,
  input  logic              src_inc,
  input  logic              dst_inc,
  input  logic              irq_en,
  input  logic [SEL_W-1:0]  periph_sel,
  input  logic              ext_req_n,
  input  logic [NMOD-1:0]   periph_tx_req,
  input  logic [NMOD-1:0]   periph_rx_req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [DATA_W-1:0] wr_data,
  output logic              bus_own,
  output logic              te,
  output logic              end_irq,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_count
);

  localparam logic [1:0] MODE_AUTO = 2'b00;
  localparam logic [1:0] MODE_EXT  = 2'b01;
  localparam logic [1:0] MODE_PER  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               state;
  logic              pend;
  logic [DATA_W-1:0] hold_data;
  logic [MID_W-1:0]  sel_mid;
  logic [1:0]        sel_kind;
  logic              periph_hit, req_line, go_ok, want;
  logic              rd_fire, wr_fire, last_unit;
  logic [ADDR_W-1:0] step;
  logic [CNT_W-1:0]  cnt_dec;

  assign sel_mid    = periph_sel[SEL_W-1:2];
  assign sel_kind   = periph_sel[1:0];
  assign periph_hit = (sel_kind == 2'b01 && periph_tx_req[sel_mid]) ||
                      (sel_kind == 2'b10 && periph_rx_req[sel_mid]);
  assign req_line   = (req_mode == MODE_EXT && !ext_req_n) ||
                      (req_mode == MODE_PER && periph_hit);
  assign go_ok      = ch_en && master_en && !te && !addr_err && !nmi_flag;
  assign want       = (req_mode == MODE_AUTO) || pend || req_line;

  always_comb begin
    case (unit_size)
      2'b00:   step = ADDR_W'(1);
      2'b01:   step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end

  assign rd_fire   = rd_valid && rd_ready;
  assign wr_fire   = wr_valid && wr_ready;
  assign cnt_dec   = cur_count - CNT_W'(1);
  assign last_unit = (cnt_dec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pend      <= 1'b0;
      hold_data <= '0;
      te        <= 1'b0;
      cur_src   <= '0;
      cur_dst   <= '0;
      cur_count <= '0;
    end else begin
      if (te_clr) te <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cfg_load) begin
            cur_src   <= cfg_src;
            cur_dst   <= cfg_dst;
            cur_count <= cfg_count;
          end else if (go_ok && cur_count != '0 && want) begin
            state <= S_RD;
            pend  <= 1'b0;
          end
        end
        S_RD: begin
          pend <= pend | req_line;
          if (rd_fire) begin
            hold_data <= rd_data;
            state     <= S_WR;
          end
        end
        S_WR: begin
          pend <= pend | req_line;
          if (wr_fire) begin
            cur_count <= cnt_dec;
            if (src_inc) cur_src <= cur_src + step;
            if (dst_inc) cur_dst <= cur_dst + step;
            if (last_unit) begin
              te    <= 1'b1;
              pend  <= 1'b0;
              state <= S_IDLE;
            end else if (burst_mode && go_ok) begin
              state <= S_RD;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = (state == S_RD);
  assign wr_valid = (state == S_WR);
  assign bus_own  = (state != S_IDLE);
  assign rd_addr  = cur_src;
  assign wr_addr  = cur_dst;
  assign rd_size  = unit_size;
  assign wr_size  = unit_size;
  assign wr_data  = hold_data;
  assign end_irq  = te && irq_en;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              ch_en,
  input logic              master_en,
  input logic              addr_err,
  input logic              nmi_flag,
  input logic              burst_mode,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              bus_own,
  input logic              te,
  input logic [CNT_W-1:0]  cur_count
);

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(ch_en && master_en && !te && !addr_err && !nmi_flag)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R5
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (cur_count == $past(cur_count) - CNT_W'(1))); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_valid && wr_ready) && !(cfg_load && !bus_own)) |=> $stable(cur_count)); // R7
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cur_count == CNT_W'(1)) |=> te); // R8
  AST_END_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (te && !bus_own) |=> !bus_own); // R8
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && wr_valid && wr_ready) |=> !bus_own); // R10
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !bus_own) |=> !bus_own); // R12

endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .ch_en(ch_en), .master_en(master_en),
  .addr_err(addr_err), .nmi_flag(nmi_flag), .burst_mode(burst_mode),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .bus_own(bus_own), .te(te), .cur_count(cur_count)
);

// File: tb/dma_channel_bench.sv
`timescale 1ns/1ps
module dma_channel_bench;
  localparam int AW = 32, DW = 32, CW = 16, MW = 6, NM = 1 << MW;

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, ch_en = 0, master_en = 0, te_clr = 0, addr_err = 0, nmi_flag = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_count = 0;
  logic [1:0] req_mode = 0, unit_size = 0;
  logic burst_mode = 0, src_inc = 0, dst_inc = 0, irq_en = 0, ext_req_n = 1;
  logic [MW+1:0] periph_sel = 0;
  logic [NM-1:0] periph_tx_req = 0, periph_rx_req = 0;
  logic rd_valid, rd_ready = 0, wr_valid, wr_ready = 0, bus_own, te, end_irq;
  logic [AW-1:0] rd_addr, wr_addr, cur_src, cur_dst;
  logic [DW-1:0] rd_data, wr_data;
  logic [1:0] rd_size, wr_size;
  logic [CW-1:0] cur_count;

  int checks = 0, failures = 0, units = 0, rises = 0;
  bit stall = 0, bus_prev = 0;
  logic [AW-1:0] exp_src = 0, exp_dst = 0;
  logic [CW-1:0] exp_cnt = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [AW-1:0] stepf(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  assign rd_data = memf(rd_addr);

  dma_channel u_dma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .ch_en(ch_en), .master_en(master_en), .te_clr(te_clr),
    .addr_err(addr_err), .nmi_flag(nmi_flag), .req_mode(req_mode), .burst_mode(burst_mode),
    .unit_size(unit_size), .src_inc(src_inc), .dst_inc(dst_inc), .irq_en(irq_en),
    .periph_sel(periph_sel), .ext_req_n(ext_req_n), .periph_tx_req(periph_tx_req),
    .periph_rx_req(periph_rx_req), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .bus_own(bus_own), .te(te),
    .end_irq(end_irq), .cur_src(cur_src), .cur_dst(cur_dst), .cur_count(cur_count));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (stall) begin rd_ready = 0; wr_ready = 0; end
    else begin rd_ready = ($urandom % 4) != 0; wr_ready = ($urandom % 4) != 0; end
    if (bus_own && !bus_prev) rises++;
    bus_prev = bus_own;
    if (rd_valid && rd_ready) begin
      check(rd_addr == exp_src, "R5 read address", rd_addr, exp_src);
      check(rd_size == unit_size, "R6 read size", rd_size, unit_size);
    end
    if (wr_valid && wr_ready) begin
      check(wr_addr == exp_dst, "R5 write address", wr_addr, exp_dst);
      check(wr_data == memf(exp_src), "R5 write data", wr_data, memf(exp_src));
      check(wr_size == unit_size, "R6 write size", wr_size, unit_size);
      check(cur_count == exp_cnt, "R7 count before write", cur_count, exp_cnt);
      if (src_inc) exp_src = exp_src + stepf(unit_size);
      if (dst_inc) exp_dst = exp_dst + stepf(unit_size);
      exp_cnt = exp_cnt - 1;
      units++;
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic setcfg(input logic [1:0] m, input bit b, input logic [1:0] s, input bit si, input bit di);
    @(negedge clk);
    req_mode = m; burst_mode = b; unit_size = s; src_inc = si; dst_inc = di;
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = c; cfg_load = 1;
    exp_src = s; exp_dst = d; exp_cnt = c;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic clear_te;
    @(negedge clk); te_clr = 1;
    @(negedge clk); te_clr = 0;
  endtask

  task automatic wait_te;
    for (int i = 0; i < 4000 && !te; i++) @(negedge clk);
    cyc(2);
  endtask

  task automatic pulse_ext;
    @(negedge clk); ext_req_n = 0;
    @(negedge clk); ext_req_n = 1;
  endtask

  task automatic pulse_per(input bit rx, input int m);
    @(negedge clk); if (rx) periph_rx_req[m] = 1; else periph_tx_req[m] = 1;
    @(negedge clk); periph_rx_req = 0; periph_tx_req = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int u0, r0;
    void'($urandom(32'd1234));
    cyc(4);
    check(!bus_own && !rd_valid && !wr_valid, "R1 reset bus idle", bus_own, 0);
    check(!te && cur_count == 0, "R1 reset flag and count", {te, cur_count}, 0);
    rst_n = 1;
    cyc(2);

    // R1 gating flags
    irq_en = 1;
    setcfg(2'b00, 1, 2'b10, 1, 1);
    load(32'h100, 32'h200, 4);
    ch_en = 1; master_en = 1; addr_err = 1; cyc(20);
    check(units == 0 && cur_count == 4, "R1 address error blocks", units, 0);
    addr_err = 0; nmi_flag = 1; cyc(20);
    check(units == 0, "R1 nmi blocks", units, 0);
    nmi_flag = 0; master_en = 0; cyc(20);
    check(units == 0, "R1 global enable blocks", units, 0);
    master_en = 1; ch_en = 0; cyc(20);
    check(units == 0 && !bus_own, "R1 channel enable blocks", units, 0);

    // R2 R9 R8 auto burst
    r0 = rises;
    ch_en = 1; wait_te();
    check(units == 4, "R2 auto units", units, 4);
    check(rises - r0 == 1, "R9 burst holds bus", rises - r0, 1);
    check(te && end_irq, "R8 end flag and irq", {te, end_irq}, 2'b11);
    check(cur_src == 32'h110 && cur_dst == 32'h210, "R6 word advance", cur_src, 32'h110);
    check(cur_count == 0, "R7 count zero", cur_count, 0);

    // R8 requests ignored while te
    u0 = units; cyc(20);
    check(units == u0 && !bus_own, "R8 ignored while te", units, u0);
    irq_en = 0; cyc(1);
    check(!end_irq, "R8 irq masked", end_irq, 0);
    clear_te(); cyc(10);
    check(!te && units == u0 && !bus_own, "R12 zero count no start", units, u0);

    // R10 cycle steal, byte, fixed source
    r0 = rises; u0 = units;
    setcfg(2'b00, 0, 2'b00, 0, 1);
    load(32'h300, 32'h400, 4);
    wait_te();
    check(units - u0 == 4, "R10 steal units", units - u0, 4);
    check(rises - r0 == 4, "R10 bus released per unit", rises - r0, 4);
    check(cur_src == 32'h300 && cur_dst == 32'h404, "R6 fixed source byte dest", cur_src, 32'h300);
    ch_en = 0; clear_te();

    // R3 external pin
    setcfg(2'b01, 0, 2'b01, 1, 1);
    load(32'h500, 32'h600, 5);
    ch_en = 1; u0 = units; cyc(10);
    check(units == u0, "R3 no request no unit", units, u0);
    pulse_ext(); cyc(30);
    check(units - u0 == 1, "R3 single pulse one unit", units - u0, 1);
    u0 = units; stall = 1; cyc(2);
    pulse_ext();
    for (int i = 0; i < 50 && !bus_own; i++) @(negedge clk);
    pulse_ext();
    cyc(3); stall = 0; cyc(40);
    check(units - u0 == 2, "R3 latched request served once", units - u0, 2);
    check(cur_count == 2 && cur_dst == 32'h606, "R3 count and half-word dest", cur_count, 2);

    // R4 peripheral selection
    ch_en = 0;
    setcfg(2'b10, 0, 2'b10, 1, 1);
    load(32'h700, 32'h800, 6);
    ch_en = 1; periph_sel = 8'h22; u0 = units;
    pulse_per(0, 8); cyc(20);
    check(units == u0, "R4 unselected kind ignored", units, u0);
    pulse_per(1, 8); cyc(20);
    check(units - u0 == 1, "R4 receive selected", units - u0, 1);
    periph_sel = 8'h23; u0 = units;
    pulse_per(0, 8); pulse_per(1, 8); cyc(20);
    check(units == u0, "R4 kind 11 selects nothing", units, u0);
    periph_sel = 8'h21;
    pulse_per(0, 9); cyc(20);
    check(units == u0, "R4 other module ignored", units, u0);
    pulse_per(0, 8); cyc(20);
    check(units - u0 == 1, "R4 transmit selected", units - u0, 1);
    periph_sel = 8'hFE; u0 = units;
    pulse_per(1, 63); cyc(20);
    check(units - u0 == 1, "R4 top module receive", units - u0, 1);

    // R11 R12 disable mid burst, load ignored while busy
    ch_en = 0;
    setcfg(2'b00, 1, 2'b10, 1, 1);
    load(32'hA00, 32'hB00, 20);
    stall = 1; cyc(2); ch_en = 1;
    for (int i = 0; i < 50 && !bus_own; i++) @(negedge clk);
    u0 = units;
    master_en = 0;
    cfg_count = 99; cfg_src = 0; cfg_load = 1; @(negedge clk); cfg_load = 0;
    cyc(2); stall = 0; cyc(40);
    check(units - u0 == 1, "R11 in-flight unit completes then stops", units - u0, 1);
    check(cur_count == 19 && !te && !bus_own, "R11 count intact", cur_count, 19);
    check(cur_src == 32'hA04, "R12 load ignored while busy", cur_src, 32'hA04);
    master_en = 1; wait_te();
    check(units - u0 == 20 && cur_dst == 32'hB50, "R11 resume to end", units - u0, 20);

    // randomized runs
    for (int k = 0; k < 14; k++) begin
      logic [1:0] sz; bit bm, si, di; logic [CW-1:0] n; logic [AW-1:0] s0, d0, es, ed;
      sz = 2'($urandom % 4); bm = 1'($urandom % 2); si = 1'($urandom % 2); di = 1'($urandom % 2);
      n = CW'(1 + $urandom % 6);
      s0 = {$urandom % 32'h10000, 4'h0}; d0 = {$urandom % 32'h10000, 4'h0};
      ch_en = 0; clear_te();
      setcfg(2'b00, bm, sz, si, di);
      load(s0, d0, n);
      u0 = units; r0 = rises; ch_en = 1; wait_te();
      es = si ? s0 + n * stepf(sz) : s0;
      ed = di ? d0 + n * stepf(sz) : d0;
      check(units - u0 == int'(n) && te, "R7 random unit total", units - u0, n);
      check(cur_src == es && cur_dst == ed, "R6 random final addresses", cur_src, es);
      if (bm) check(rises - r0 == 1, "R9 random burst", rises - r0, 1);
      else    check(rises - r0 == int'(n), "R10 random steal", rises - r0, n);
    end

    summary();
    $finish;
  end
endmodule